// File: doc/BRIEF.md
# Dual-Input Up/Down Cascadable Counter

This block is a presettable binary counter with no direction bit. Instead it has two count inputs: a rising edge on the up input adds one, and a rising edge on the down input subtracts one. Both count inputs rest HIGH, and only one of them pulses at a time. An active-low level-sensitive load copies a data word into the count. An active-high clear forces the count to zero and overrides every other input.

Two active-low outputs let stages be chained with no glue logic. The carry output is LOW while the count is all ones and the up input is LOW. The borrow output is LOW while the count is zero and the down input is LOW. Each of these pulses is therefore as wide as the count pulse that causes the wrap. Carry feeds the up input of the next stage, and borrow feeds its down input.

All inputs are asynchronous to the system clock. Each one passes through a synchronizer of SYNC_STAGES flops, and the block edge-detects the synchronized count levels. If both count inputs are LOW together, or if both rise in the same cycle, the block treats this as a protocol fault: the count is held and a one-cycle error pulse is raised.

Top module: `updn_chain_counter`

## Requirements
- R1: Each synchronized rising edge of the up input increments the count modulo 2^WIDTH, so the all-ones value becomes zero.
- R2: Each synchronized rising edge of the down input decrements the count modulo 2^WIDTH, so zero becomes all ones.
- R3: While load_n_i is LOW and clear is LOW, the count takes data_i and ignores both count inputs; load is a level, not an edge.
- R4: While clr_i is HIGH, the count goes to zero whatever load, data and the count inputs do.
- R5: carry_n_o is LOW exactly when the count is all ones and the synchronized up input is LOW.
- R6: borrow_n_o is LOW exactly when the count is zero and the synchronized down input is LOW.
- R7: Two stages chained carry-to-up and borrow-to-down count as one 2*WIDTH-bit counter, including the wrap from all ones to zero and from zero to all ones.
- R8: When both synchronized count inputs are LOW, or both rise in the same cycle, the count is held and err_o is HIGH for exactly one cycle at the start of the fault.
- R9: After reset the count is zero, carry_n_o and borrow_n_o are HIGH, and err_o is LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_up_i | input | 1 | Up count input, rests HIGH, rising edge counts |
| cnt_dn_i | input | 1 | Down count input, rests HIGH, rising edge counts |
| load_n_i | input | 1 | Active-low level-sensitive parallel load |
| clr_i | input | 1 | Active-high clear, highest priority |
| data_i | input | WIDTH | Preset value |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low overflow pulse for chaining |
| borrow_n_o | output | 1 | Active-low underflow pulse for chaining |
| err_o | output | 1 | One-cycle protocol fault pulse |

## Verification
A wrong count register shows on count_o SYNC_STAGES+1 cycles after the input edge that should have moved it. In a chain it shows even more visibly, because the upper stage then takes a step too many or too few at the next wrap. A wrong wrap or compare term shows as a missing or extra carry or borrow pulse, and it shows while the triggering count input is still LOW, before that input rises again. The bench sweeps a two-stage chain through more than a full period in each direction, so every value and both wrap points pass through these checks.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

   typedef enum logic [2:0] {
      OP_HOLD,
      OP_CLEAR,
      OP_LOAD,
      OP_INC,
      OP_DEC,
      OP_FAULT
   } cnt_op_e;

   function automatic cnt_op_e select_op(
      input logic clr,
      input logic ld_n,
      input logic up_ev,
      input logic dn_ev,
      input logic up_lvl,
      input logic dn_lvl
   );
      if (clr)                                  return OP_CLEAR;
      else if (!ld_n)                           return OP_LOAD;
      else if ((up_ev && dn_ev) || (!up_lvl && !dn_lvl)) return OP_FAULT;
      else if (up_ev)                           return OP_INC;
      else if (dn_ev)                           return OP_DEC;
      else                                      return OP_HOLD;
   endfunction

endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("updn_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg[s] <= RST_VAL;
            end else if (s == 0) begin
               stg[s] <= async_i;
            end else begin
               stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/updn_edge.sv
module updn_edge #(
   parameter int           W       = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] rise_o
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl_i;
   end

   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         assign rise_o[b] = lvl_i[b] & ~prev_q[b];
      end
   endgenerate
endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
   import updn_cnt_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             ld_n_i,
   input  logic [WIDTH-1:0] data_i,
   input  logic             up_lvl_i,
   input  logic             dn_lvl_i,
   input  logic             up_ev_i,
   input  logic             dn_ev_i,
   output logic [WIDTH-1:0] count_o,
   output logic             carry_n_o,
   output logic             borrow_n_o,
   output logic             err_o
);
   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

   cnt_op_e          op;
   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_d;
   logic             fault_q;
   logic             err_q;
   logic             is_fault;

   assign op       = select_op(clr_i, ld_n_i, up_ev_i, dn_ev_i, up_lvl_i, dn_lvl_i);
   assign is_fault = (op == OP_FAULT);

   always_comb begin
      unique case (op)
         OP_CLEAR: cnt_d = '0;
         OP_LOAD:  cnt_d = data_i;
         OP_INC:   cnt_d = cnt_q + ONE;
         OP_DEC:   cnt_d = cnt_q - ONE;
         default:  cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fault_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         fault_q <= is_fault;
         err_q   <= is_fault & ~fault_q;
      end
   end

   assign count_o    = cnt_q;
   assign err_o      = err_q;
   assign carry_n_o  = ~((cnt_q == ALL_ONES) & ~up_lvl_i);
   assign borrow_n_o = ~((cnt_q == '0) & ~dn_lvl_i);
endmodule

// File: rtl/updn_chain_counter.sv
module updn_chain_counter #(
   parameter int WIDTH       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_up_i,
   input  logic             cnt_dn_i,
   input  logic             load_n_i,
   input  logic             clr_i,
   input  logic [WIDTH-1:0] data_i,
   output logic [WIDTH-1:0] count_o,
   output logic             carry_n_o,
   output logic             borrow_n_o,
   output logic             err_o
);
   localparam int CTRL_W = 4;
   localparam logic [CTRL_W-1:0] CTRL_RST = 4'b0111; // {clr, ld_n, dn, up}

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("updn_chain_counter: WIDTH must be at least 1");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_s;
   logic [WIDTH-1:0]  data_s;
   logic              clr_s, ld_n_s, up_s, dn_s;
   logic [1:0]        rise;
   logic              up_ev, dn_ev;

   updn_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_RST)) u_ctrl_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({clr_i, load_n_i, cnt_dn_i, cnt_up_i}),
      .sync_o  (ctrl_s)
   );

   updn_sync #(.W(WIDTH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (data_i),
      .sync_o  (data_s)
   );

   assign up_s   = ctrl_s[0];
   assign dn_s   = ctrl_s[1];
   assign ld_n_s = ctrl_s[2];
   assign clr_s  = ctrl_s[3];

   updn_edge #(.W(2), .RST_VAL(2'b11)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  ({dn_s, up_s}),
      .rise_o (rise)
   );

   assign up_ev = rise[0];
   assign dn_ev = rise[1];

   updn_count_core #(.WIDTH(WIDTH)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr_s),
      .ld_n_i     (ld_n_s),
      .data_i     (data_s),
      .up_lvl_i   (up_s),
      .dn_lvl_i   (dn_s),
      .up_ev_i    (up_ev),
      .dn_ev_i    (dn_ev),
      .count_o    (count_o),
      .carry_n_o  (carry_n_o),
      .borrow_n_o (borrow_n_o),
      .err_o      (err_o)
   );
endmodule

// File: rtl/updn_chain_counter_chk.sv
module updn_chain_counter_chk #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] count_o,
   input logic             borrow_n_o,
   input logic             carry_n_o,
   input logic             err_o,
   input logic             clr_lvl,
   input logic             ld_n_lvl,
   input logic [WIDTH-1:0] ld_data,
   input logic             up_lvl,
   input logic             dn_lvl,
   input logic             up_ev,
   input logic             dn_ev
);
   assert_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_lvl && ld_n_lvl && up_ev && !dn_ev && dn_lvl)
      |=> count_o == WIDTH'($past(count_o) + 1'b1));

   assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_lvl && ld_n_lvl && dn_ev && !up_ev && up_lvl)
      |=> count_o == WIDTH'($past(count_o) - 1'b1));

   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_lvl && !ld_n_lvl) |=> count_o == $past(ld_data));

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_lvl |=> count_o == '0);

   assert_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!carry_n_o) |-> (!up_lvl && count_o == {WIDTH{1'b1}}));

   assert_borrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!borrow_n_o) |-> (!dn_lvl && count_o == '0));

   assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $stable(count_o));

   assert_fault_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o);
endmodule

bind updn_chain_counter updn_chain_counter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .count_o    (count_o),
   .borrow_n_o (borrow_n_o),
   .carry_n_o  (carry_n_o),
   .err_o      (err_o),
   .clr_lvl    (clr_s),
   .ld_n_lvl   (ld_n_s),
   .ld_data    (data_s),
   .up_lvl     (up_s),
   .dn_lvl     (dn_s),
   .up_ev      (up_ev),
   .dn_ev      (dn_ev)
);

// File: tb/test_updn_chain_counter.sv
module test_updn_chain_counter;
   localparam int CLK_PERIOD = 10;
   localparam int W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up = 1'b1, dn = 1'b1, load_n = 1'b1, clr = 1'b0;
   logic [2*W-1:0] data = '0;

   logic [W-1:0] cnt_lo, cnt_hi;
   logic carry_lo, borrow_lo, carry_hi, borrow_hi, err_lo, err_hi;

   int total = 0;
   int bad = 0;
   int err_seen = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   updn_chain_counter #(.WIDTH(W)) i_updn_chain_counter (
      .clk(clk), .rst_n(rst_n), .cnt_up_i(up), .cnt_dn_i(dn),
      .load_n_i(load_n), .clr_i(clr), .data_i(data[W-1:0]),
      .count_o(cnt_lo), .carry_n_o(carry_lo), .borrow_n_o(borrow_lo), .err_o(err_lo)
   );

   updn_chain_counter #(.WIDTH(W)) i_updn_chain_counter_hi (
      .clk(clk), .rst_n(rst_n), .cnt_up_i(carry_lo), .cnt_dn_i(borrow_lo),
      .load_n_i(load_n), .clr_i(clr), .data_i(data[2*W-1:W]),
      .count_o(cnt_hi), .carry_n_o(carry_hi), .borrow_n_o(borrow_hi), .err_o(err_hi)
   );

   always @(negedge clk) if (rst_n && err_lo) err_seen++;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int actual, input int expected);
      total++;
      if (actual != expected) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   task automatic pulse_up(inout int v);
      up = 1'b0;
      tick(6);
      check("R5 R7 chain carry", carry_hi, (v == 255) ? 0 : 1);
      up = 1'b1;
      tick(8);
      v = (v + 1) % 256;
      check("R1 R7 up count", {cnt_hi, cnt_lo}, v);
   endtask

   task automatic pulse_dn(inout int v);
      dn = 1'b0;
      tick(6);
      check("R6 R7 chain borrow", borrow_hi, (v == 0) ? 0 : 1);
      dn = 1'b1;
      tick(8);
      v = (v + 255) % 256;
      check("R2 R7 down count", {cnt_hi, cnt_lo}, v);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int v;
      int e0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R9 reset state
      check("R9 count", {cnt_hi, cnt_lo}, 0);
      check("R9 carry", carry_hi & carry_lo, 1);
      check("R9 borrow", borrow_hi & borrow_lo, 1);
      check("R9 err", err_lo | err_hi, 0);

      // R1 R5 R7 full upward sweep through the 255 -> 0 wrap
      v = 0;
      for (int i = 0; i < 260; i++) pulse_up(v);
      // R2 R6 R7 full downward sweep through the 0 -> 255 wrap
      for (int i = 0; i < 262; i++) pulse_dn(v);

      // R3 load while the up input pulses: data wins
      data = 8'hA5;
      tick(3);
      load_n = 1'b0;
      tick(2);
      up = 1'b0; tick(3); up = 1'b1; tick(3);
      check("R3 load held", {cnt_hi, cnt_lo}, 8'hA5);
      load_n = 1'b1;
      tick(6);
      check("R3 load released", {cnt_hi, cnt_lo}, 8'hA5);
      v = 8'hA5;
      pulse_up(v);
      pulse_dn(v);

      // R4 clear together with load: clear wins
      data = 8'h3C;
      tick(3);
      clr = 1'b1; load_n = 1'b0;
      tick(3);
      dn = 1'b0; tick(3); dn = 1'b1; tick(3);
      check("R4 clear over load", {cnt_hi, cnt_lo}, 0);
      clr = 1'b0; load_n = 1'b1;
      tick(6);
      check("R4 after release", {cnt_hi, cnt_lo}, 0);

      // R3 load to a mid value, then R8 both inputs LOW
      data = 8'h37;
      tick(3);
      load_n = 1'b0; tick(5); load_n = 1'b1; tick(5);
      check("R3 load mid", {cnt_hi, cnt_lo}, 8'h37);
      e0 = err_seen;
      up = 1'b0; tick(4);
      dn = 1'b0; tick(6);
      check("R8 held during fault", {cnt_hi, cnt_lo}, 8'h37);
      up = 1'b1; dn = 1'b1;
      tick(8);
      check("R8 held after simultaneous rise", {cnt_hi, cnt_lo}, 8'h37);
      check("R8 one err pulse", err_seen - e0, 1);
      v = 8'h37;
      pulse_up(v);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule